// File: doc/BRIEF.md
# Vectored Interrupt Entry and Register-Set Switcher

This block performs the state change a processor core makes when an external vectored interrupt controller hands it an interrupt. The controller supplies a handler address, the number of the register set the handler should run in, an interrupt level and a non-maskable flag. On a single-cycle `take_i` pulse, the block builds the new status word. It saves the interrupted context and moves the program counter to the handler address.

The context is the old status word and the return address. The return address is the interrupted PC plus 4. It is saved in the per-set slots of the destination register set, or in the exception-status register when the destination is set 0. It is saved only when the exception-handling (EH) bit of the old status is clear. When the saved status goes into a nonzero set that differs from the old current set, it is tagged with a switch flag.

The core keeps the status word and PC here. It can overwrite them through a load port, for example after returning from a handler. The slot contents of any set can be read back through a combinational read port.

Status word layout:

| Bit(s) | Field |
|---|---|
| 0 | previous interrupt enable |
| 1 | user mode |
| 2 | EH |
| 3 | interrupt handler (IH) |
| 9:4 | interrupt level |
| 15:10 | current register set |
| 21:16 | previous register set |
| 22 | NMI |
| 23 | register-set interrupt enable |
| 31 | set-switch flag |

All other bits are kept as they are.

Top module: `irq_vec_switch`

## Requirements
- R1: After reset, `status_o`, `estatus_o` and every slot's saved status and saved return address are 0, and `pc_o` equals `RESET_PC`.
- R2: One cycle after `take_i` is sampled high, `pc_o` equals the `hnd_addr_i` value sampled with it.
- R3: On a take, the new status holds `req_set_i` (zero-extended) in bits 15:10, `req_lvl_i` (zero-extended) in bits 9:4 and `req_nmi_i` in bit 22.
- R4: On a take, the new status has bit 3 set and bits 1 and 23 cleared. Bits 0, 2, 31 and all unassigned bits are kept from the old status.
- R5: On a take with old bit 2 clear, bits 21:16 of the new status take the old bits 15:10. With old bit 2 set, bits 21:16 are kept.
- R6: On a take with old bit 2 clear and `req_set_i` = 0, `estatus_o` receives the old status unchanged.
- R7: On a take with old bit 2 clear and `req_set_i` ≠ 0, that set's saved-status slot receives the old status, with bit 31 set when `req_set_i` differs from old bits 15:10. In this case `estatus_o` is unchanged.
- R8: On a take with old bit 2 clear, the saved-return-address slot of set `req_set_i` receives the old `pc_o` + 4, modulo 2^AW.
- R9: On a take with old bit 2 set, `estatus_o` and every slot keep their values.
- R10: With `ld_i` high and `take_i` low, `status_o` and `pc_o` load `ld_status_i` and `ld_pc_i`. When both are high, the take wins and the load is ignored.
- R11: With `take_i` and `ld_i` both low, `status_o`, `pc_o`, `estatus_o` and all slots keep their values.
- R12: `rd_sstatus_o` and `rd_ea_o` show, in the same cycle, the slots of the set selected by `rd_set_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| take_i | input | 1 | take the presented interrupt this cycle |
| hnd_addr_i | input | AW | handler address from the controller |
| req_set_i | input | SET_W | destination register set |
| req_lvl_i | input | LVL_W | requested interrupt level |
| req_nmi_i | input | 1 | non-maskable flag |
| ld_i | input | 1 | load status and PC from the core |
| ld_status_i | input | 32 | status value to load |
| ld_pc_i | input | AW | PC value to load |
| rd_set_i | input | SET_W | register set to read |
| status_o | output | 32 | current status word |
| pc_o | output | AW | current PC |
| estatus_o | output | 32 | exception-status register |
| rd_sstatus_o | output | 32 | saved status of the selected set |
| rd_ea_o | output | AW | saved return address of the selected set |

## Verification
The assertions assume that `req_set_i` names an existing set whenever `take_i` is high. They also assume that `take_i` and `ld_i` are never unknown after reset.

The bench drives only set numbers below `NUM_SETS`. Inputs change on the falling edge, so no sample lands on a transition. It presents status words with EH both set and clear, and destination sets equal to, different from and equal to zero relative to the current set. This covers every save branch, including the case where the return address wraps around.

// File: rtl/irqsw_pkg.sv
package irqsw_pkg;
    localparam int ST_W      = 32;
    localparam int FLD_W     = 6;
    localparam int ST_PIE    = 0;
    localparam int ST_U      = 1;
    localparam int ST_EH     = 2;
    localparam int ST_IH     = 3;
    localparam int ST_IL_LO  = 4;
    localparam int ST_CRS_LO = 10;
    localparam int ST_PRS_LO = 16;
    localparam int ST_NMI    = 22;
    localparam int ST_RSIE   = 23;
    localparam int ST_SRS    = 31;
endpackage

// File: rtl/irqsw_status_calc.sv
module irqsw_status_calc
    import irqsw_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int LVL_W = 6
) (
    input  logic [ST_W-1:0]  old_st,
    input  logic [SET_W-1:0] req_set,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic             req_nmi,
    output logic [ST_W-1:0]  new_st,
    output logic [ST_W-1:0]  save_st,
    output logic             save_en,
    output logic             save_to_es
);
    logic [FLD_W-1:0] old_crs;
    logic [FLD_W-1:0] want_crs;

    always_comb begin
        old_crs  = old_st[ST_CRS_LO +: FLD_W];
        want_crs = FLD_W'(req_set);

        new_st = old_st;
        new_st[ST_CRS_LO +: FLD_W] = want_crs;
        new_st[ST_IL_LO +: FLD_W]  = FLD_W'(req_lvl);
        new_st[ST_NMI]             = req_nmi;
        new_st[ST_RSIE]            = 1'b0;
        new_st[ST_U]               = 1'b0;
        new_st[ST_IH]              = 1'b1;
        if (!old_st[ST_EH]) begin
            new_st[ST_PRS_LO +: FLD_W] = old_crs;
        end

        save_en    = !old_st[ST_EH];
        save_to_es = (req_set == '0);
        save_st    = old_st;
        if (!save_to_es && (want_crs != old_crs)) begin
            save_st[ST_SRS] = 1'b1;
        end
    end
endmodule

// File: rtl/irqsw_set_store.sv
module irqsw_set_store
    import irqsw_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int SET_W    = 3,
    parameter int AW       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_st_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [ST_W-1:0]  wr_st,
    input  logic [AW-1:0]    wr_ea,
    input  logic [SET_W-1:0] rd_set,
    output logic [ST_W-1:0]  rd_st,
    output logic [AW-1:0]    rd_ea
);
    logic [ST_W-1:0] st_q [NUM_SETS];
    logic [AW-1:0]   ea_q [NUM_SETS];

    for (genvar i = 0; i < NUM_SETS; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (32'(wr_set) == i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i] <= '0;
                ea_q[i] <= '0;
            end else if (hit) begin
                ea_q[i] <= wr_ea;
                if (wr_st_en) begin
                    st_q[i] <= wr_st;
                end
            end
        end
    end

    always_comb begin
        rd_st = '0;
        rd_ea = '0;
        if (32'(rd_set) < NUM_SETS) begin
            rd_st = st_q[rd_set];
            rd_ea = ea_q[rd_set];
        end
    end
endmodule

// File: rtl/irq_vec_switch.sv
module irq_vec_switch
    import irqsw_pkg::*;
#(
    parameter int          NUM_SETS = 8,
    parameter int          SET_W    = $clog2(NUM_SETS),
    parameter int          LVL_W    = 6,
    parameter int          AW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [AW-1:0]    hnd_addr_i,
    input  logic [SET_W-1:0] req_set_i,
    input  logic [LVL_W-1:0] req_lvl_i,
    input  logic             req_nmi_i,
    input  logic             ld_i,
    input  logic [ST_W-1:0]  ld_status_i,
    input  logic [AW-1:0]    ld_pc_i,
    input  logic [SET_W-1:0] rd_set_i,
    output logic [ST_W-1:0]  status_o,
    output logic [AW-1:0]    pc_o,
    output logic [ST_W-1:0]  estatus_o,
    output logic [ST_W-1:0]  rd_sstatus_o,
    output logic [AW-1:0]    rd_ea_o
);
    localparam int SET_LIMIT = $clog2(NUM_SETS);
    localparam logic [AW-1:0] PC_STEP = AW'(4);

    if (NUM_SETS < 2 || SET_W > SET_LIMIT || SET_W > FLD_W || LVL_W > FLD_W) begin : g_bad_cfg
        $error("irq_vec_switch: register-set or level field too wide for configuration");
    end

    typedef struct packed {
        logic [ST_W-1:0] status;
        logic [AW-1:0]   pc;
        logic [ST_W-1:0] estatus;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [ST_W-1:0] calc_new_st;
    logic [ST_W-1:0] calc_save_st;
    logic            calc_save_en;
    logic            calc_to_es;
    logic            slot_wr;
    logic            slot_st_wr;

    irqsw_status_calc #(.SET_W(SET_W), .LVL_W(LVL_W)) i_calc (
        .old_st    (ctx_q.status),
        .req_set   (req_set_i),
        .req_lvl   (req_lvl_i),
        .req_nmi   (req_nmi_i),
        .new_st    (calc_new_st),
        .save_st   (calc_save_st),
        .save_en   (calc_save_en),
        .save_to_es(calc_to_es)
    );

    always_comb begin
        ctx_d      = ctx_q;
        slot_wr    = 1'b0;
        slot_st_wr = 1'b0;
        if (take_i) begin
            ctx_d.status = calc_new_st;
            ctx_d.pc     = hnd_addr_i;
            if (calc_save_en) begin
                slot_wr = 1'b1;
                if (calc_to_es) begin
                    ctx_d.estatus = ctx_q.status;
                end else begin
                    slot_st_wr = 1'b1;
                end
            end
        end else if (ld_i) begin
            ctx_d.status = ld_status_i;
            ctx_d.pc     = ld_pc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q.status  <= '0;
            ctx_q.pc      <= AW'(RESET_PC);
            ctx_q.estatus <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    irqsw_set_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W), .AW(AW)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_wr),
        .wr_st_en(slot_st_wr),
        .wr_set  (req_set_i),
        .wr_st   (calc_save_st),
        .wr_ea   (ctx_q.pc + PC_STEP),
        .rd_set  (rd_set_i),
        .rd_st   (rd_sstatus_o),
        .rd_ea   (rd_ea_o)
    );

    assign status_o  = ctx_q.status;
    assign pc_o      = ctx_q.pc;
    assign estatus_o = ctx_q.estatus;
endmodule

// File: rtl/irq_vec_switch_chk.sv
module irq_vec_switch_chk
    import irqsw_pkg::*;
#(
    parameter int SET_W = 3,
    parameter int LVL_W = 6,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_i,
    input logic [AW-1:0]    hnd_addr_i,
    input logic [SET_W-1:0] req_set_i,
    input logic [LVL_W-1:0] req_lvl_i,
    input logic             req_nmi_i,
    input logic             ld_i,
    input logic [ST_W-1:0]  status_o,
    input logic [AW-1:0]    pc_o,
    input logic [ST_W-1:0]  estatus_o
);
    assert_handler_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> pc_o == $past(hnd_addr_i));

    assert_fields_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (status_o[ST_CRS_LO +: FLD_W] == FLD_W'($past(req_set_i)))
                && (status_o[ST_IL_LO +: FLD_W] == FLD_W'($past(req_lvl_i)))
                && (status_o[ST_NMI] == $past(req_nmi_i)));

    assert_mode_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> status_o[ST_IH] && !status_o[ST_U] && !status_o[ST_RSIE]
                && (status_o[ST_EH] == $past(status_o[ST_EH])));

    assert_prev_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !status_o[ST_EH]) |=>
            status_o[ST_PRS_LO +: FLD_W] == $past(status_o[ST_CRS_LO +: FLD_W]));

    assert_es_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !status_o[ST_EH] && req_set_i == '0) |=> estatus_o == $past(status_o));

    assert_no_save_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && status_o[ST_EH]) |=> $stable(estatus_o));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !ld_i) |=> $stable(status_o) && $stable(pc_o) && $stable(estatus_o));
endmodule

bind irq_vec_switch irq_vec_switch_chk #(.SET_W(SET_W), .LVL_W(LVL_W), .AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_i),
    .hnd_addr_i(hnd_addr_i),
    .req_set_i (req_set_i),
    .req_lvl_i (req_lvl_i),
    .req_nmi_i (req_nmi_i),
    .ld_i      (ld_i),
    .status_o  (status_o),
    .pc_o      (pc_o),
    .estatus_o (estatus_o)
);

// File: tb/test_irq_vec_switch.sv
module test_irq_vec_switch;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 8;
    localparam int SW = 3;
    localparam int LW = 6;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [31:0] st;
        logic [31:0] pc;
        logic [2:0]  set;
        logic [5:0]  lvl;
        logic        nmi;
        logic [31:0] hnd;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{st: 32'h0080_0003, pc: 32'h0000_1000, set: 3'd0, lvl: 6'd5,  nmi: 1'b0, hnd: 32'h0000_2000},
        '{st: 32'h0080_0C01, pc: 32'h0000_1100, set: 3'd5, lvl: 6'd10, nmi: 1'b1, hnd: 32'h0000_2100},
        '{st: 32'h0000_0C00, pc: 32'h0000_1200, set: 3'd3, lvl: 6'd63, nmi: 1'b0, hnd: 32'h0000_2200},
        '{st: 32'h0000_0C04, pc: 32'h0000_1300, set: 3'd7, lvl: 6'd1,  nmi: 1'b0, hnd: 32'h0000_2300},
        '{st: 32'h0000_1C02, pc: 32'hFFFF_FFFC, set: 3'd0, lvl: 6'd2,  nmi: 1'b1, hnd: 32'h0000_2400},
        '{st: 32'h0005_0801, pc: 32'h0000_1500, set: 3'd7, lvl: 6'd0,  nmi: 1'b1, hnd: 32'h0000_2500}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic take_i = 1'b0;
    logic [31:0] hnd_addr_i = '0;
    logic [SW-1:0] req_set_i = '0;
    logic [LW-1:0] req_lvl_i = '0;
    logic req_nmi_i = 1'b0;
    logic ld_i = 1'b0;
    logic [31:0] ld_status_i = '0;
    logic [31:0] ld_pc_i = '0;
    logic [SW-1:0] rd_set_i = '0;
    logic [31:0] status_o, pc_o, estatus_o, rd_sstatus_o, rd_ea_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_ss [NSETS];
    logic [31:0] m_ea [NSETS];
    logic [31:0] m_es;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_switch i_irq_vec_switch (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .hnd_addr_i(hnd_addr_i),
        .req_set_i(req_set_i), .req_lvl_i(req_lvl_i), .req_nmi_i(req_nmi_i),
        .ld_i(ld_i), .ld_status_i(ld_status_i), .ld_pc_i(ld_pc_i), .rd_set_i(rd_set_i),
        .status_o(status_o), .pc_o(pc_o), .estatus_o(estatus_o),
        .rd_sstatus_o(rd_sstatus_o), .rd_ea_o(rd_ea_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_status(input logic [31:0] o, input logic [2:0] s,
                                                 input logic [5:0] l, input logic n);
        logic [31:0] r = o;
        r[15:10] = {3'b000, s};
        r[9:4]   = l;
        r[22]    = n;
        r[3]     = 1'b1;
        r[1]     = 1'b0;
        r[23]    = 1'b0;
        if (!o[2]) r[21:16] = o[15:10];
        return r;
    endfunction

    task automatic load(input logic [31:0] st, input logic [31:0] pc);
        @(negedge clk);
        ld_i = 1'b1; ld_status_i = st; ld_pc_i = pc;
        @(negedge clk);
        ld_i = 1'b0;
    endtask

    task automatic take(input logic [2:0] s, input logic [5:0] l, input logic n, input logic [31:0] h);
        @(negedge clk);
        take_i = 1'b1; req_set_i = s; req_lvl_i = l; req_nmi_i = n; hnd_addr_i = h;
        @(negedge clk);
        take_i = 1'b0;
    endtask

    task automatic model_take(input logic [31:0] o, input logic [31:0] pc, input logic [2:0] s);
        if (!o[2]) begin
            m_ea[s] = pc + 32'd4;
            if (s == 3'd0) m_es = o;
            else begin
                m_ss[s] = o;
                if (o[15:10] != {3'b000, s}) m_ss[s][31] = 1'b1;
            end
        end
    endtask

    task automatic check_slot(input string req, input logic [2:0] s);
        rd_set_i = s;
        #1;
        check(req, rd_sstatus_o, m_ss[s]);
        check(req, rd_ea_o, m_ea[s]);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NSETS; i++) begin
            m_ss[i] = '0;
            m_ea[i] = '0;
        end
        m_es = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", status_o, 32'h0);
        check("R1 pc", pc_o, 32'h0);
        check("R1 estatus", estatus_o, 32'h0);
        for (int i = 0; i < NSETS; i++) check_slot("R1 slot", 3'(i));

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            load(VECS[v].st, VECS[v].pc);
            check("R10 load status", status_o, VECS[v].st);
            check("R10 load pc", pc_o, VECS[v].pc);
            take(VECS[v].set, VECS[v].lvl, VECS[v].nmi, VECS[v].hnd);
            model_take(VECS[v].st, VECS[v].pc, VECS[v].set);
            check("R2 pc", pc_o, VECS[v].hnd);
            check("R3 R4 R5 status", status_o,
                  model_status(VECS[v].st, VECS[v].set, VECS[v].lvl, VECS[v].nmi));
            check("R6 R7 R9 estatus", estatus_o, m_es);
            check_slot("R7 R8 R9 slot", VECS[v].set);
        end
        // R9 R7 R12: every slot matches the model after all takes
        for (int i = 0; i < NSETS; i++) check_slot("R12 slot sweep", 3'(i));

        // R10 take wins over simultaneous load
        load(32'h0000_0800, 32'h0000_3000);
        @(negedge clk);
        take_i = 1'b1; ld_i = 1'b1; ld_status_i = 32'hDEAD_0000; ld_pc_i = 32'h0000_9999;
        req_set_i = 3'd6; req_lvl_i = 6'd9; req_nmi_i = 1'b0; hnd_addr_i = 32'h0000_4000;
        @(negedge clk);
        take_i = 1'b0; ld_i = 1'b0;
        model_take(32'h0000_0800, 32'h0000_3000, 3'd6);
        check("R10 take wins pc", pc_o, 32'h0000_4000);
        check("R10 take wins status", status_o, model_status(32'h0000_0800, 3'd6, 6'd9, 1'b0));
        check_slot("R8 switch slot", 3'd6);

        // R11 hold with no control
        repeat (4) @(negedge clk);
        check("R11 hold status", status_o, model_status(32'h0000_0800, 3'd6, 6'd9, 1'b0));
        check("R11 hold pc", pc_o, 32'h0000_4000);
        check("R11 hold estatus", estatus_o, m_es);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule